// File: doc/BRIEF.md
# Coprocessor Load/Store Execution Unit

This block is the memory-access stage of a small coprocessor that has four 16-bit general registers. It accepts one decoded operation at a time through a valid/ready handshake. It then spends a fixed number of cycles executing that operation against a memory of 32-bit words. It drives a single-cycle request to that memory and, for loads, writes the fetched half-word back into the register file.

The unit holds the register file and a private byte-offset register. Stores are tagged: beside the 16-bit register value they record the program counter of the issuing instruction and a 2-bit label. This lets a host processor that reads the memory later see where each value came from. A set-offset command loads the offset register. An auto-incrementing store uses that offset and then advances it by one word, so a run of such stores fills consecutive words. Loads take a signed byte offset, convert it to a word offset and place the low half-word of the addressed word into a register.

Opcode encoding on `op_code`: 1 = tagged store, 2 = auto-increment store, 3 = set offset, 4 and 5 = low half-word load (two mnemonics, same behaviour). Any other code is a no-operation.

Top module: `cop_lsu`

## Requirements
- R1: After reset `busy` is 0, `op_ready` is 1, `mem_we`, `mem_re` and `wb_en` are 0, all four registers read as zero and the offset register is zero.
- R2: A tagged store (code 1) drives `mem_we` in the first busy cycle with `mem_addr` = (R[`op_ra`] + (sign-extended 13-bit `op_imm` arithmetically shifted right by 2)) mod 2^ADDR_W and `mem_wdata` = {`op_pc`[10:0], 3'b000, `op_label`[1:0], R[`op_rv`][15:0]}; it does not use or change the offset register.
- R3: Set offset (code 3) copies `op_imm` into the 13-bit offset register and makes no memory access and no write-back.
- R4: An auto-increment store (code 2) writes the same tagged word as R2 to (R[`op_ra`] + offset>>>2) mod 2^ADDR_W, then adds 4 to the offset so that the next such store lands one word higher.
- R5: Every operation keeps `busy` high for exactly 4 cycles, starting in the cycle after the handshake; `op_ready` is high when idle and in the final busy cycle.
- R6: A store raises `mem_we` for exactly one cycle and never `mem_re`; a load raises `mem_re` for exactly one cycle, in the first busy cycle, and expects `mem_rdata_lo` in the following cycle.
- R7: A load (codes 4 and 5) addresses memory as in R2 and, in the final busy cycle, drives `wb_en` with `wb_idx` = `op_rv` and `wb_data` = low 16 bits of the addressed word, which R[`op_rv`] holds from then on.
- R8: An operation presented while `op_ready` is low is held off, not lost: it is accepted on the first cycle `op_ready` is high, back-to-back with the previous one.
- R9: Address sums wrap modulo the memory depth, so negative offsets reach the top of memory and a rising offset wraps to word 0.
- R10: Codes 0, 6 and 7 occupy the 4 busy cycles with no memory access, no write-back and no change to the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit can take an operation this cycle |
| op_code | input | 3 | Operation code |
| op_ra | input | 2 | Address register index |
| op_rv | input | 2 | Value register: store source or load destination |
| op_imm | input | 13 | Signed byte offset, or new offset value |
| op_label | input | 2 | Store tag label |
| op_pc | input | 11 | Program counter of the operation |
| busy | output | 1 | Operation in execution |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 11 | Word address |
| mem_wdata | output | 32 | Tagged write word |
| mem_rdata_lo | input | 16 | Low half of the word read, one cycle after `mem_re` |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | 2 | Write-back register index |
| wb_data | output | 16 | Write-back value |

## Verification
The bench first fills registers through loads with positive, negative and register-derived offsets. This separates the arithmetic shift and wrap from a plain add, and shows that the low half-word is taken. Stores with different labels, program counters and value registers show that each tag field sits in its place and that R0 keeps its reset zero. A run of auto-increment stores before and after a negative set-offset, with no-operation codes in between, shows the reset offset, the one-word step, the wrap through word 0 and that other codes leave the offset alone. A store offered while the unit is busy tells a held operation from a dropped or early one.

// File: rtl/cop_lsu.sv
`timescale 1ns/1ps
module cop_lsu #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11,
  parameter int PC_W   = 11,
  parameter int IMM_W  = 13,
  parameter int RIDX_W = 2,
  parameter int LAT    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       op_valid,
  output logic                       op_ready,
  input  logic [2:0]                 op_code,
  input  logic [RIDX_W-1:0]          op_ra,
  input  logic [RIDX_W-1:0]          op_rv,
  input  logic [IMM_W-1:0]           op_imm,
  input  logic [1:0]                 op_label,
  input  logic [PC_W-1:0]            op_pc,
  output logic                       busy,
  output logic                       mem_we,
  output logic                       mem_re,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [PC_W+DATA_W+4:0]     mem_wdata,
  input  logic [DATA_W-1:0]          mem_rdata_lo,
  output logic                       wb_en,
  output logic [RIDX_W-1:0]          wb_idx,
  output logic [DATA_W-1:0]          wb_data
);
  localparam int NREG  = 1 << RIDX_W;
  localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [2:0] C_ST   = 3'd1;
  localparam logic [2:0] C_STI  = 3'd2;
  localparam logic [2:0] C_SOFF = 3'd3;
  localparam logic [2:0] C_LD   = 3'd4;
  localparam logic [2:0] C_LDL  = 3'd5;

  logic [DATA_W-1:0] rf [NREG];
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        code_q;
  logic [RIDX_W-1:0] ra_q, rv_q;
  logic [IMM_W-1:0]  imm_q, off_q;
  logic [1:0]        lbl_q;
  logic [PC_W-1:0]   pc_q;
  logic [DATA_W-1:0] ld_q;

  logic first, last, accept, is_st, is_sti, is_soff, is_ld;
  logic signed [IMM_W-1:0] disp, step;
  logic [ADDR_W-1:0] step_a;

  assign first   = busy_q && (cnt_q == '0);
  assign last    = busy_q && (cnt_q == CNT_W'(LAT-1));
  assign op_ready = !busy_q || last;
  assign accept  = op_valid && op_ready;
  assign is_st   = (code_q == C_ST);
  assign is_sti  = (code_q == C_STI);
  assign is_soff = (code_q == C_SOFF);
  assign is_ld   = (code_q == C_LD) || (code_q == C_LDL);

  assign disp   = is_sti ? off_q : imm_q;
  assign step   = disp >>> 2;
  assign step_a = ADDR_W'(step);

  assign busy      = busy_q;
  assign mem_addr  = rf[ra_q][ADDR_W-1:0] + step_a;
  assign mem_wdata = {pc_q, 3'b000, lbl_q, rf[rv_q]};
  assign mem_we    = first && (is_st || is_sti);
  assign mem_re    = first && is_ld;
  assign wb_en     = last && is_ld;
  assign wb_idx    = rv_q;
  assign wb_data   = ld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      code_q <= '0;
      ra_q   <= '0;
      rv_q   <= '0;
      imm_q  <= '0;
      lbl_q  <= '0;
      pc_q   <= '0;
      off_q  <= '0;
      ld_q   <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        code_q <= op_code;
        ra_q   <= op_ra;
        rv_q   <= op_rv;
        imm_q  <= op_imm;
        lbl_q  <= op_label;
        pc_q   <= op_pc;
      end else if (last) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
      if (first && is_sti)  off_q <= off_q + IMM_W'(4);
      if (first && is_soff) off_q <= imm_q;
      if (busy_q && cnt_q == CNT_W'(1) && is_ld) ld_q <= mem_rdata_lo;
      if (wb_en) rf[rv_q] <= ld_q;
    end
  end

  p_accept_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> busy);
  p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  p_re_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re && !wb_en);
  p_wb_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> busy && $past(busy));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |-> busy);
  p_sti_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && is_sti) |=> off_q == $past(off_q) + IMM_W'(4));
endmodule

// File: tb/tb_cop_lsu.sv
`timescale 1ns/1ps
module tb_cop_lsu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_code = '0;
  logic [1:0]  op_ra = '0, op_rv = '0, op_label = '0;
  logic [12:0] op_imm = '0;
  logic [10:0] op_pc = '0;
  logic        busy, mem_we, mem_re, wb_en;
  logic [10:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [15:0] rdata_q = '0;
  logic [1:0]  wb_idx;
  logic [15:0] wb_data;

  logic [31:0] mem_m [2048];
  int n_chk = 0, n_bad = 0;
  int er [4];
  int o_busy, o_we, o_re, o_wb, o_addr, o_wdata, o_wbidx, o_wbdata, o_wbk, o_rdy3, o_after;

  always #2.5 clk = ~clk;

  cop_lsu dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_ra(op_ra), .op_rv(op_rv), .op_imm(op_imm),
    .op_label(op_label), .op_pc(op_pc), .busy(busy), .mem_we(mem_we),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata_lo(rdata_q), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  always @(posedge clk) begin
    if (mem_we) mem_m[mem_addr] <= mem_wdata;
    if (mem_re) rdata_q <= mem_m[mem_addr][15:0];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int waddr(input int base, input logic [12:0] imm);
    int s;
    s = imm[12] ? int'(imm) - 8192 : int'(imm);
    return (base + (s >>> 2)) & 2047;
  endfunction

  function automatic logic [31:0] tag(input logic [10:0] pc, input logic [1:0] l, input int v);
    return {pc, 3'b000, l, v[15:0]};
  endfunction

  task automatic exec(input logic [2:0] c, input logic [1:0] ra, input logic [1:0] rv,
                      input logic [12:0] imm, input logic [1:0] l, input logic [10:0] pc);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; op_ra = ra; op_rv = rv; op_imm = imm; op_label = l; op_pc = pc;
    while (!op_ready) @(negedge clk);
    @(posedge clk);
    #1 op_valid = 1'b0;
    o_busy = 0; o_we = 0; o_re = 0; o_wb = 0; o_addr = -1; o_wdata = 0; o_wbk = -1;
    o_wbidx = 0; o_wbdata = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (busy) o_busy++;
      if (mem_we) o_we++;
      if (mem_re) o_re++;
      if (mem_we || mem_re) begin o_addr = int'(mem_addr); o_wdata = mem_wdata; end
      if (wb_en) begin o_wb++; o_wbk = k; o_wbidx = wb_idx; o_wbdata = wb_data; end
      if (k == 3) o_rdy3 = op_ready;
    end
    @(negedge clk);
    o_after = busy;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 ready", op_ready, 1);
    chk("R1 we/re/wb", {mem_we, mem_re, wb_en}, 0);
  endtask

  task automatic do_load(input logic [2:0] c, input int ra, input int rv, input logic [12:0] imm, input string req);
    int a;
    a = waddr(er[ra], imm);
    exec(c, 2'(ra), 2'(rv), imm, 2'd0, 11'd0);
    chk({req, " load address"}, o_addr, a);
    chk("R6 one read no write", {o_re[7:0], o_we[7:0]}, 16'h0100);
    chk("R7 wb final cycle", o_wbk, 3);
    chk("R7 wb index", o_wbidx, rv);
    chk("R7 wb data", o_wbdata, mem_m[a][15:0]);
    chk("R5 busy four cycles", o_busy, 4);
    chk("R5 ready in last cycle", o_rdy3, 1);
    chk("R5 idle after", o_after, 0);
    er[rv] = int'(mem_m[a][15:0]);
  endtask

  task automatic t_loads;
    do_load(3'd4, 0, 1, 13'd40, "R7");
    do_load(3'd5, 0, 2, 13'h1FF8, "R9");
    do_load(3'd4, 1, 3, 13'd4, "R7");
  endtask

  task automatic t_store;
    exec(3'd1, 2'd3, 2'd2, 13'd12, 2'd2, 11'h5A3);
    chk("R2 address", o_addr, waddr(er[3], 13'd12));
    chk("R2 tagged word", o_wdata, tag(11'h5A3, 2'd2, er[2]));
    chk("R6 one write", {o_we[7:0], o_re[7:0], o_wb[7:0]}, 24'h010000);
    exec(3'd1, 2'd0, 2'd0, 13'h1FFC, 2'd1, 11'h001);
    chk("R9 negative wrap", o_addr, 2047);
    chk("R1 R0 zero in tag", o_wdata, tag(11'h001, 2'd1, 0));
  endtask

  task automatic t_offset;
    exec(3'd2, 2'd0, 2'd1, 13'd0, 2'd1, 11'd7);
    chk("R1 offset zero at reset", o_addr, 0);
    chk("R4 tagged word", o_wdata, tag(11'd7, 2'd1, er[1]));
    exec(3'd2, 2'd0, 2'd1, 13'd0, 2'd1, 11'd8);
    chk("R4 next word", o_addr, 1);
    exec(3'd3, 2'd0, 2'd0, 13'h1FF8, 2'd0, 11'd9);
    chk("R3 no access", {o_we[7:0], o_re[7:0], o_wb[7:0]}, 0);
    chk("R3 busy", o_busy, 4);
    exec(3'd2, 2'd0, 2'd3, 13'd0, 2'd0, 11'd10);
    chk("R4 after set offset", o_addr, 2046);
    exec(3'd2, 2'd0, 2'd3, 13'd0, 2'd0, 11'd11);
    chk("R4 step", o_addr, 2047);
    exec(3'd2, 2'd0, 2'd3, 13'd0, 2'd3, 11'd12);
    chk("R9 offset wraps to 0", o_addr, 0);
  endtask

  task automatic t_unknown;
    exec(3'd6, 2'd0, 2'd1, 13'd100, 2'd0, 11'd0);
    chk("R10 code 6 idle", {o_we[7:0], o_re[7:0], o_wb[7:0]}, 0);
    chk("R10 code 6 busy", o_busy, 4);
    exec(3'd7, 2'd1, 2'd2, 13'd44, 2'd0, 11'd0);
    chk("R10 code 7 idle", {o_we[7:0], o_re[7:0], o_wb[7:0]}, 0);
    exec(3'd0, 2'd1, 2'd2, 13'd44, 2'd0, 11'd0);
    chk("R10 code 0 idle", {o_we[7:0], o_re[7:0], o_wb[7:0]}, 0);
    exec(3'd2, 2'd0, 2'd2, 13'd0, 2'd0, 11'd1);
    chk("R10 offset unchanged", o_addr, 1);
  endtask

  task automatic t_holdoff;
    int n;
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd1; op_ra = 2'd0; op_rv = 2'd1; op_imm = 13'd0;
    op_label = 2'd0; op_pc = 11'd3;
    @(posedge clk);
    #1 op_code = 3'd2; op_rv = 2'd2; op_label = 2'd3; op_pc = 11'h7FF;
    @(negedge clk);
    chk("R8 held off", {busy, op_ready}, 2'b10);
    n = 0;
    while (!op_ready && n < 10) begin @(negedge clk); n++; end
    chk("R8 ready at final cycle", n, 3);
    @(posedge clk);
    #1 op_valid = 1'b0;
    @(negedge clk);
    chk("R8 held op executes", {busy, mem_we}, 2'b11);
    chk("R8 held op address", mem_addr, 2);
    chk("R8 held op word", mem_wdata, tag(11'h7FF, 2'd3, er[2]));
    repeat (4) @(negedge clk);
    chk("R5 idle after held op", busy, 0);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem_m[i] = (i * 32'h9E3779B1) ^ 32'h12345678;
    for (int i = 0; i < 4; i++) er[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_loads;
    t_store;
    t_offset;
    t_unknown;
    t_holdoff;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule